// File: doc/BRIEF.md
# Byte-Lane Register Access Adapter

This block sits between a host that issues 1-, 2- or 4-byte accesses into a 128-byte I/O window and a set of register targets that accept only full 32-bit words. The window has three targets: a bank of SCSI core registers in the low 64 bytes, a bank of DMA registers in the next 32 bytes, and one bus-and-control word at byte 0x70. Any other address is undecoded.

A write that is narrower than a word, or that does not start on a word boundary, is widened into one full-word write at the aligned address. The adapter peeks at the target's current word through that target's read-data port, which has no side effects. It then places the host bytes with a fixed lane-shift rule and keeps the other bytes, all in the same cycle as the request. A read raises the target's read strobe in the request cycle. On the next cycle the adapter returns the addressed bytes moved down to bit 0 and masked to the access size.

Top module: `io_lane_adapter`

## Requirements
- R1: A read at address A selects a target as follows. A < 0x40 selects a core register with `core_idx` = A[5:2]. 0x40 <= A < 0x60 selects a DMA register with `dma_idx` = A[4:2]. A == 0x70 exactly selects the control word. Every other address, including 0x71 to 0x73, is undecoded and returns zero.
- R2: A read raises the selected target's read strobe in the request cycle. On the next cycle `host_rvalid` is 1 and `host_rdata` = (word >> 8*(A mod 4)) AND (the low 8*size bits).
- R3: An aligned 4-byte write passes `host_wdata` unchanged to `tgt_wdata`. In the same cycle it raises the write strobe of the target decoded from the address, using the same ranges as R1.
- R4: A write with a size below 4 or a nonzero A mod 4 goes to the aligned address A AND ~3. Let s = ((4 - (A mod 4)) mod 4)*8 and m = the low 8*size bits. The written word is ((wdata AND m) << s) OR (current AND NOT (m << s)), truncated to 32 bits.
- R5: The current word used for merging comes from a side-effect-free peek at the aligned address. Below 0x40 it is the core register, from 0x40 to 0x5F the DMA register, from 0x60 to 0x73 the control word, and from 0x74 upward it is zero.
- R6: A write whose aligned address is 0x60 to 0x6C or 0x74 and above raises no write strobe.
- R7: At most one of the six target strobes is high in any cycle. A write never raises a read strobe, and a read never raises a write strobe.
- R8: An access whose `host_size` is 0 or above 4 raises no strobe and produces no `host_rvalid`.
- R9: After reset `host_rvalid` and `host_rdata` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_req | input | 1 | Access request, one cycle per access |
| host_we | input | 1 | 1 = write, 0 = read |
| host_addr | input | 7 | Byte address in the window |
| host_size | input | 3 | Access size in bytes, 1 to 4 |
| host_wdata | input | 32 | Write data, right-justified |
| host_rdata | output | 32 | Read data, valid with host_rvalid |
| host_rvalid | output | 1 | Read response, one cycle after a read |
| core_idx | output | 4 | Core register index, also used for the merge peek |
| core_wr | output | 1 | Core register write strobe |
| core_rd | output | 1 | Core register read strobe |
| core_rdata | input | 32 | Core register at core_idx, side-effect free |
| dma_idx | output | 3 | DMA register index, also used for the merge peek |
| dma_wr | output | 1 | DMA register write strobe |
| dma_rd | output | 1 | DMA register read strobe |
| dma_rdata | input | 32 | DMA register at dma_idx, side-effect free |
| ctl_wr | output | 1 | Control word write strobe |
| ctl_rd | output | 1 | Control word read strobe |
| ctl_rdata | input | 32 | Control word, side-effect free |
| tgt_wdata | output | 32 | Full word to write to the strobed target |

## Verification
Write strobes, indices and `tgt_wdata` are combinational, so they are due in the request cycle itself. `host_rdata` and `host_rvalid` are due one clock edge later. The bench applies each request at a falling edge and checks strobes and the merged word 1 ns later, before the next rising edge. It checks the read response at the following falling edge, after the edge that registers it. The bench's register model takes its write on that same rising edge, so a read that follows a narrow write sees the merged word.

// File: rtl/io_lane_adapter.sv
module io_lane_adapter #(
  parameter int AW           = 7,
  parameter int DW           = 32,
  parameter int CORE_END     = 64,
  parameter int DMA_END      = 96,
  parameter int CTL_ADDR     = 112,
  parameter int CTL_SPAN_END = 116,
  localparam int BYTES = DW / 8,
  localparam int OW    = $clog2(BYTES),
  localparam int SW    = OW + 1,
  localparam int CIW   = $clog2(CORE_END / BYTES),
  localparam int DIW   = $clog2((DMA_END - CORE_END) / BYTES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_req,
  input  logic           host_we,
  input  logic [AW-1:0]  host_addr,
  input  logic [SW-1:0]  host_size,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  output logic           host_rvalid,
  output logic [CIW-1:0] core_idx,
  output logic           core_wr,
  output logic           core_rd,
  input  logic [DW-1:0]  core_rdata,
  output logic [DIW-1:0] dma_idx,
  output logic           dma_wr,
  output logic           dma_rd,
  input  logic [DW-1:0]  dma_rdata,
  output logic           ctl_wr,
  output logic           ctl_rd,
  input  logic [DW-1:0]  ctl_rdata,
  output logic [DW-1:0]  tgt_wdata
);
  localparam logic [AW-1:0] CORE_END_A = AW'(CORE_END);
  localparam logic [AW-1:0] DMA_END_A  = AW'(DMA_END);
  localparam logic [AW-1:0] CTL_A      = AW'(CTL_ADDR);
  localparam logic [AW-1:0] CTL_SPAN_A = AW'(CTL_SPAN_END);
  localparam logic [SW-1:0] FULL       = SW'(BYTES);

  logic [OW-1:0] off;
  logic [AW-1:0] al;
  logic          size_ok, rd_acc, wr_acc;
  logic [DW-1:0] lane_mask, cur, sel;
  logic [OW-1:0] wsh_b;

  assign off     = host_addr[OW-1:0];
  assign al      = {host_addr[AW-1:OW], {OW{1'b0}}};
  assign size_ok = (host_size != '0) && (host_size <= FULL);
  assign rd_acc  = host_req && !host_we && size_ok;
  assign wr_acc  = host_req && host_we && size_ok;

  always_comb
    for (int b = 0; b < BYTES; b++)
      lane_mask[8*b +: 8] = {8{SW'(b) < host_size}};

  assign core_idx = host_addr[OW +: CIW];
  assign dma_idx  = host_addr[OW +: DIW];

  logic rd_core, rd_dma, rd_ctl, wr_core, wr_dma, wr_ctl, mg_ctl;
  assign rd_core = host_addr < CORE_END_A;
  assign rd_dma  = !rd_core && (host_addr < DMA_END_A);
  assign rd_ctl  = host_addr == CTL_A;
  assign wr_core = al < CORE_END_A;
  assign wr_dma  = !wr_core && (al < DMA_END_A);
  assign wr_ctl  = al == CTL_A;
  assign mg_ctl  = !wr_core && !wr_dma && (al < CTL_SPAN_A);

  assign core_rd = rd_acc && rd_core;
  assign dma_rd  = rd_acc && rd_dma;
  assign ctl_rd  = rd_acc && rd_ctl;
  assign core_wr = wr_acc && wr_core;
  assign dma_wr  = wr_acc && wr_dma;
  assign ctl_wr  = wr_acc && wr_ctl;

  assign cur = wr_core ? core_rdata :
               wr_dma  ? dma_rdata  :
               mg_ctl  ? ctl_rdata  : '0;

  assign wsh_b     = OW'(0) - off;
  assign tgt_wdata = ((host_wdata & lane_mask) << {wsh_b, 3'b000}) |
                     (cur & ~(lane_mask << {wsh_b, 3'b000}));

  assign sel = rd_core ? core_rdata :
               rd_dma  ? dma_rdata  :
               rd_ctl  ? ctl_rdata  : '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      host_rvalid <= 1'b0;
      host_rdata  <= '0;
    end else begin
      host_rvalid <= rd_acc;
      if (rd_acc) host_rdata <= (sel >> {off, 3'b000}) & lane_mask;
    end

  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({core_wr, dma_wr, ctl_wr, core_rd, dma_rd, ctl_rd}));

  a_r7_read_strobe_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (core_rd || dma_rd || ctl_rd) |-> (host_req && !host_we));

  a_r7_write_strobe_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr || dma_wr || ctl_wr) |-> (host_req && host_we));

  a_r8_bad_size_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (host_size == '0 || host_size > FULL) |->
      !(core_wr || dma_wr || ctl_wr || core_rd || dma_rd || ctl_rd));

  a_r2_response_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we && host_size != '0 && host_size <= FULL) |=> host_rvalid);

  a_r2_no_spurious_response: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_req && !host_we) |=> !host_rvalid);

  a_r2_byte_read_zero_extended: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we && host_size == SW'(1)) |=> (host_rdata[DW-1:8] == '0));

  a_r1_undecoded_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_we && host_size != '0 && host_size <= FULL &&
     host_addr >= DMA_END_A && host_addr != CTL_A) |=> (host_rdata == '0));

  a_r3_full_word_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we && host_size == FULL && host_addr[OW-1:0] == '0) |->
      (tgt_wdata == host_wdata));

  a_r6_unmapped_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_we && host_addr >= DMA_END_A && host_addr[AW-1:OW] != CTL_A[AW-1:OW]) |->
      !(core_wr || dma_wr || ctl_wr));
endmodule

// File: tb/io_lane_adapter_tb.sv
`timescale 1ns/1ps
module io_lane_adapter_tb_top;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        host_req = 1'b0, host_we = 1'b0;
  logic [6:0]  host_addr = '0;
  logic [2:0]  host_size = 3'd4;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata, tgt_wdata, core_rdata, dma_rdata, ctl_rdata;
  logic        host_rvalid, core_wr, core_rd, dma_wr, dma_rd, ctl_wr, ctl_rd;
  logic [3:0]  core_idx;
  logic [2:0]  dma_idx;

  int n_tests = 0, n_fail = 0;
  logic [31:0] core_m [16];
  logic [31:0] dma_m [8];
  logic [31:0] ctl_m;

  always #4 clk = ~clk;

  io_lane_adapter dut_i (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
    .host_addr(host_addr), .host_size(host_size), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_rvalid(host_rvalid),
    .core_idx(core_idx), .core_wr(core_wr), .core_rd(core_rd), .core_rdata(core_rdata),
    .dma_idx(dma_idx), .dma_wr(dma_wr), .dma_rd(dma_rd), .dma_rdata(dma_rdata),
    .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .ctl_rdata(ctl_rdata), .tgt_wdata(tgt_wdata));

  assign core_rdata = core_m[core_idx];
  assign dma_rdata  = dma_m[dma_idx];
  assign ctl_rdata  = ctl_m;

  always @(posedge clk)
    if (!rst_n) begin
      for (int i = 0; i < 16; i++) core_m[i] <= {8'hC0, 8'(i), 8'hA5, 8'(i)};
      for (int i = 0; i < 8; i++)  dma_m[i]  <= {8'hD0, 8'(i), 8'h5A, 8'(i)};
      ctl_m <= 32'h7000_00C7;
    end else begin
      if (core_wr) core_m[core_idx] <= tgt_wdata;
      if (dma_wr)  dma_m[dma_idx]   <= tgt_wdata;
      if (ctl_wr)  ctl_m            <= tgt_wdata;
    end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] size_mask(input logic [2:0] sz);
    logic [31:0] m = '0;
    for (int b = 0; b < 4; b++) if (b < int'(sz)) m[8*b +: 8] = 8'hFF;
    return m;
  endfunction

  function automatic logic [31:0] ref_read(input logic [6:0] a, input logic [2:0] sz);
    logic [31:0] w;
    if (a < 7'h40)      w = core_m[a[5:2]];
    else if (a < 7'h60) w = dma_m[a[4:2]];
    else if (a == 7'h70) w = ctl_m;
    else                w = '0;
    return (w >> (8 * int'(a[1:0]))) & size_mask(sz);
  endfunction

  function automatic logic [31:0] ref_write(input logic [6:0] a, input logic [2:0] sz,
                                            input logic [31:0] d);
    logic [6:0]  al = {a[6:2], 2'b00};
    logic [31:0] cur, m;
    int          s = ((4 - int'(a[1:0])) % 4) * 8;
    if (al < 7'h40)      cur = core_m[al[5:2]];
    else if (al < 7'h60) cur = dma_m[al[4:2]];
    else if (al < 7'h74) cur = ctl_m;
    else                 cur = '0;
    m = size_mask(sz);
    return ((d & m) << s) | (cur & ~(m << s));
  endfunction

  task automatic do_acc(input logic we, input logic [6:0] a, input logic [2:0] sz,
                        input logic [31:0] d, input logic [1:0] kind, input string tag,
                        input logic use_exp, input logic [31:0] exp_in);
    logic [31:0] exp;
    logic        good = (sz >= 3'd1 && sz <= 3'd4);
    @(negedge clk);
    host_req = 1'b1; host_we = we; host_addr = a; host_size = sz; host_wdata = d;
    #1;
    exp = use_exp ? exp_in : (we ? ref_write(a, sz, d) : ref_read(a, sz));
    if (we) begin
      chk({tag, " wr strobes"}, {29'd0, core_wr, dma_wr, ctl_wr},
          {29'd0, kind == 2'd1, kind == 2'd2, kind == 2'd3});
      chk("R7 no rd strobe on write", {29'd0, core_rd, dma_rd, ctl_rd}, '0);
      if (kind != 2'd0) chk({tag, " merged word"}, tgt_wdata, exp);
    end else begin
      chk({tag, " rd strobes"}, {29'd0, core_rd, dma_rd, ctl_rd},
          {29'd0, kind == 2'd1, kind == 2'd2, kind == 2'd3});
      chk("R7 no wr strobe on read", {29'd0, core_wr, dma_wr, ctl_wr}, '0);
    end
    if (kind == 2'd1) chk("R1 core index", {28'd0, core_idx}, {28'd0, a[5:2]});
    if (kind == 2'd2) chk("R1 dma index", {29'd0, dma_idx}, {29'd0, a[4:2]});
    @(negedge clk);
    host_req = 1'b0;
    chk({tag, " rvalid"}, {31'd0, host_rvalid}, {31'd0, !we && good});
    if (!we && good) chk({tag, " rdata"}, host_rdata, exp);
  endtask

  localparam int NV = 12;
  localparam logic [44:0] VEC [NV] = '{
    {1'b1, 7'h08, 3'd4, 32'h1122_3344, 2'd1},
    {1'b0, 7'h08, 3'd4, 32'h0,         2'd1},
    {1'b0, 7'h0A, 3'd2, 32'h0,         2'd1},
    {1'b1, 7'h13, 3'd1, 32'hFFFF_FF9E, 2'd1},
    {1'b0, 7'h10, 3'd4, 32'h0,         2'd1},
    {1'b1, 7'h4C, 3'd4, 32'hCAFE_F00D, 2'd2},
    {1'b0, 7'h4D, 3'd1, 32'h0,         2'd2},
    {1'b1, 7'h5C, 3'd3, 32'h00AB_CDEF, 2'd2},
    {1'b0, 7'h5C, 3'd4, 32'h0,         2'd2},
    {1'b0, 7'h3F, 3'd1, 32'h0,         2'd1},
    {1'b0, 7'h7F, 3'd1, 32'h0,         2'd0},
    {1'b1, 7'h78, 3'd4, 32'hDEAD_BEEF, 2'd0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 rvalid after reset", {31'd0, host_rvalid}, '0);
    chk("R9 rdata after reset", host_rdata, '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R7 idle no strobes", {26'd0, core_wr, dma_wr, ctl_wr, core_rd, dma_rd, ctl_rd}, '0);

    for (int i = 0; i < NV; i++)
      do_acc(VEC[i][44], VEC[i][43:37], VEC[i][36:34], VEC[i][33:2], VEC[i][1:0],
             VEC[i][44] ? "R3/R4 table" : "R2 table", 1'b0, '0);

    do_acc(1'b1, 7'h05, 3'd1, 32'h0000_003C, 2'd1, "R4 offset1 lane", 1'b1, 32'h3C01_A501);
    do_acc(1'b0, 7'h07, 3'd1, 32'h0, 2'd1, "R2 top byte", 1'b1, 32'h0000_003C);
    do_acc(1'b0, 7'h05, 3'd2, 32'h0, 2'd1, "R2 mid half", 1'b1, 32'h0000_01A5);
    do_acc(1'b1, 7'h42, 3'd2, 32'h0000_1234, 2'd2, "R4 offset2 half", 1'b1, 32'h1234_5A00);
    do_acc(1'b1, 7'h71, 3'd2, 32'h0000_BEEF, 2'd3, "R5 ctl merge", 1'b1, 32'hEF00_00C7);
    do_acc(1'b0, 7'h70, 3'd4, 32'h0, 2'd3, "R1 ctl read", 1'b1, 32'hEF00_00C7);
    do_acc(1'b0, 7'h71, 3'd1, 32'h0, 2'd0, "R1 ctl offset undecoded", 1'b1, 32'h0);
    do_acc(1'b0, 7'h62, 3'd2, 32'h0, 2'd0, "R1 gap read", 1'b1, 32'h0);
    do_acc(1'b1, 7'h62, 3'd1, 32'h0000_0055, 2'd0, "R6 gap write", 1'b0, '0);
    do_acc(1'b0, 7'h70, 3'd4, 32'h0, 2'd3, "R6 ctl untouched", 1'b1, 32'hEF00_00C7);
    do_acc(1'b1, 7'h7C, 3'd4, 32'h1234_5678, 2'd0, "R6 top write", 1'b0, '0);
    do_acc(1'b0, 7'h00, 3'd0, 32'h0, 2'd0, "R8 size0 read", 1'b0, '0);
    do_acc(1'b1, 7'h00, 3'd5, 32'hFFFF_FFFF, 2'd0, "R8 size5 write", 1'b0, '0);
    do_acc(1'b0, 7'h00, 3'd4, 32'h0, 2'd1, "R8 core0 untouched", 1'b1, 32'hC000_A500);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule